// File: doc/BRIEF.md
# Bouncing Up/Down Binary Counter

This block is a small synchronous binary counter that sweeps back and forth between its two extremes without any outside control. After reset it rises from zero to all-ones, turns around, falls back to zero, turns around again, and repeats for as long as the count enable stays high. Every count bit is a toggle cell whose toggle term is decoded from the lower bits and the current direction. The direction lives in its own toggle flip-flop rather than being derived from the count. That flop is told to flip one count before each extreme, so the turnaround lands exactly on the extreme value.

Typical uses are triangle-wave or scan-pattern generation, ping-pong address sequencing and similar jobs where a value must bounce between two fixed limits. The width is a parameter, with a default of three bits. A second parameter chooses how the toggle terms are formed: a serial AND chain or one wide AND per bit. Both forms give the same behaviour.

Top module: `bnc_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets `count` to 0 and `dir_up` to 1 (1 means counting up, 0 means counting down). Reset takes priority over `en`.
- R2: While `en` is low, `count` and `dir_up` both keep their values across the clock edge.
- R3: With `en` high and `dir_up` = 1, `count` increases by exactly one at the next edge.
- R4: With `en` high and `dir_up` = 0, `count` decreases by exactly one at the next edge.
- R5: With `en` high, `dir_up` = 1 and `count` equal to all-ones minus one, the next edge moves `count` to all-ones and clears `dir_up`.
- R6: With `en` high, `dir_up` = 0 and `count` equal to 1, the next edge moves `count` to 0 and sets `dir_up`.
- R7: `dir_up` changes only on an enabled edge taken from one of the two states named in R5 and R6.
- R8: Whenever `count` is all-ones, `dir_up` is 0. Whenever `count` is 0, `dir_up` is 1. Each extreme therefore appears once per sweep.
- R9: With `en` held high after reset, `count` follows 0,1,...,max,max-1,...,1,0,... and repeats every 2*(2^WIDTH-1) enabled cycles, which is 14 for the default width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; while low, all state holds |
| count | output | WIDTH | Current count value |
| dir_up | output | 1 | Direction flop: 1 = counting up, 0 = counting down |

## Verification
The counter first runs with `en` held high for several complete up/down sweeps. This exposes any fault in the per-bit toggle terms in either direction and any turnaround that lands one count early or late. A second pattern drops `en` on a regular cadence. This separates a correct hold from a counter that keeps stepping, or a direction flop that still toggles while disabled. A third pattern parks `en` low exactly on the pre-turnaround counts and on both extremes, where a hold fault in the direction flop would flip the sweep. A reset applied mid-sweep and a timed return to zero confirm the start state and the period.

// File: rtl/bnc_pkg.sv
package bnc_pkg;

   // Encoding of the direction flop; the top port dir_up carries this bit.
   typedef enum logic {
      BNC_DOWN = 1'b0,
      BNC_UP   = 1'b1
   } bnc_dir_e;

   // Toggle-term construction variants.
   localparam int unsigned BNC_TERMS_PARALLEL = 0;
   localparam int unsigned BNC_TERMS_CHAIN    = 1;

   // Number of distinct output states in one full up/down cycle.
   function automatic int unsigned bnc_period(input int unsigned width);
      return 2 * ((1 << width) - 1);
   endfunction

endpackage

// File: rtl/bnc_tcell.sv
module bnc_tcell #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic tgl,
   output logic q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= RESET_VAL;
      else if (tgl)
         q <= ~q;
   end

endmodule

// File: rtl/bnc_tterms.sv
module bnc_tterms #(
   parameter int unsigned WIDTH       = 3,
   parameter int unsigned TERMS_STYLE = 1
) (
   input  logic             en,
   input  logic             up,
   input  logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] tgl
);
   import bnc_pkg::*;

   // lo_ones[i]  : every bit below i is 1
   // lo_zeros[i] : every bit below i is 0
   logic [WIDTH-1:0] lo_ones;
   logic [WIDTH-1:0] lo_zeros;

   if (TERMS_STYLE == BNC_TERMS_CHAIN) begin : g_chain
      assign lo_ones[0]  = 1'b1;
      assign lo_zeros[0] = 1'b1;
      for (genvar i = 1; i < WIDTH; i++) begin : g_link
         assign lo_ones[i]  = lo_ones[i-1]  &  q[i-1];
         assign lo_zeros[i] = lo_zeros[i-1] & ~q[i-1];
      end
   end else begin : g_parallel
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i == 0) begin : g_lsb
            assign lo_ones[i]  = 1'b1;
            assign lo_zeros[i] = 1'b1;
         end else begin : g_upper
            assign lo_ones[i]  = &q[i-1:0];
            assign lo_zeros[i] = ~|q[i-1:0];
         end
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_sel
      assign tgl[i] = en & (up ? lo_ones[i] : lo_zeros[i]);
   end

endmodule

// File: rtl/bnc_dir_ctrl.sv
module bnc_dir_ctrl #(
   parameter int unsigned WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] q,
   output logic             up
);
   import bnc_pkg::*;

   localparam logic [WIDTH-1:0] TOP_M1 = {{(WIDTH-1){1'b1}}, 1'b0};
   localparam logic [WIDTH-1:0] BOT_P1 = {{(WIDTH-1){1'b0}}, 1'b1};

   logic near_top;
   logic near_bot;
   logic dir_tgl;

   // Decode one step ahead so the flop flips as the count reaches an extreme.
   assign near_top = (q == TOP_M1);
   assign near_bot = (q == BOT_P1);
   assign dir_tgl  = en & (up ? near_top : near_bot);

   bnc_tcell #(.RESET_VAL(BNC_UP)) u_dir (
      .clk (clk),
      .rst (rst),
      .tgl (dir_tgl),
      .q   (up)
   );

endmodule

// File: rtl/bnc_counter.sv
module bnc_counter #(
   parameter int unsigned WIDTH       = 3,
   parameter int unsigned TERMS_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [WIDTH-1:0] count,
   output logic             dir_up
);
   import bnc_pkg::*;

   if (WIDTH < 2) begin : g_bad_width
      $error("bnc_counter: WIDTH must be at least 2");
   end
   if (WIDTH > 30) begin : g_wide_width
      $error("bnc_counter: WIDTH above 30 is not supported");
   end
   if (TERMS_STYLE != BNC_TERMS_CHAIN && TERMS_STYLE != BNC_TERMS_PARALLEL) begin : g_bad_style
      $error("bnc_counter: TERMS_STYLE must select chain or parallel");
   end

   logic [WIDTH-1:0] tgl;
   logic             up_q;

   bnc_tterms #(
      .WIDTH       (WIDTH),
      .TERMS_STYLE (TERMS_STYLE)
   ) u_terms (
      .en  (en),
      .up  (up_q),
      .q   (count),
      .tgl (tgl)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      bnc_tcell #(.RESET_VAL(1'b0)) u_cell (
         .clk (clk),
         .rst (rst),
         .tgl (tgl[i]),
         .q   (count[i])
      );
   end

   bnc_dir_ctrl #(.WIDTH(WIDTH)) u_dir (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .q   (count),
      .up  (up_q)
   );

   assign dir_up = up_q;

endmodule

// File: rtl/bnc_counter_chk.sv
module bnc_counter_chk #(
   parameter int unsigned WIDTH = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [WIDTH-1:0] count,
   input logic             dir_up
);

   localparam logic [WIDTH-1:0] ALL1 = '1;
   localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (count == '0 && dir_up));

   p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(count) && $stable(dir_up)));

   p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
      (en && dir_up) |=> (count == WIDTH'($past(count) + ONE)));

   p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
      (en && !dir_up) |=> (count == WIDTH'($past(count) - ONE)));

   p_turn_at_top_r5: assert property (@(posedge clk) disable iff (rst)
      (en && dir_up && count == WIDTH'(ALL1 - ONE)) |=> (count == ALL1 && !dir_up));

   p_turn_at_bottom_r6: assert property (@(posedge clk) disable iff (rst)
      (en && !dir_up && count == ONE) |=> (count == '0 && dir_up));

   p_dir_keeps_up_r7: assert property (@(posedge clk) disable iff (rst)
      (dir_up && !(en && count == WIDTH'(ALL1 - ONE))) |=> dir_up);

   p_dir_keeps_down_r7: assert property (@(posedge clk) disable iff (rst)
      (!dir_up && !(en && count == ONE)) |=> !dir_up);

   p_extreme_dir_r8: assert property (@(posedge clk) disable iff (rst)
      ((count == ALL1) |-> !dir_up) and ((count == '0) |-> dir_up));

endmodule

bind bnc_counter bnc_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .en     (en),
   .count  (count),
   .dir_up (dir_up)
);

// File: tb/bnc_counter_tb.sv
`timescale 1ns/1ps
module bnc_counter_tb;

   localparam int unsigned WIDTH = 3;
   localparam int unsigned MAXV  = (1 << WIDTH) - 1;
   localparam int unsigned PER   = 2 * MAXV;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             en  = 1'b0;
   logic [WIDTH-1:0] count;
   logic             dir_up;

   int n_checks = 0;
   int n_fails  = 0;
   int pos      = 0;   // position in the bounce cycle, 0..PER-1
   bit done     = 0;

   always #2.5 clk = ~clk;

   bnc_counter #(.WIDTH(WIDTH)) u_dut (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .count  (count),
      .dir_up (dir_up)
   );

   function automatic int exp_count(input int p);
      return (p <= MAXV) ? p : PER - p;
   endfunction

   function automatic bit exp_up(input int p);
      return p < MAXV;
   endfunction

   task automatic check(input string req);
      int ec = exp_count(pos);
      bit eu = exp_up(pos);
      n_checks++;
      if (int'(count) != ec || dir_up != eu) begin
         n_fails++;
         $display("FAIL %s: count=%0d dir_up=%0b expected count=%0d dir_up=%0b",
                  req, count, dir_up, ec, eu);
      end
   endtask

   // One clock with the given enable; model update and check after the edge.
   task automatic tick(input bit v);
      string req;
      if (!v)                    req = "R2";
      else if (pos == MAXV - 1)  req = "R5";
      else if (pos == PER - 1)   req = "R6";
      else if (pos < MAXV)       req = "R3";
      else                       req = "R4";
      @(negedge clk);
      en = v;
      @(posedge clk);
      #1;
      if (v) pos = (pos + 1) % PER;
      check(req);
      if (pos == 0 || pos == MAXV) check("R8");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      en  = 1'b1;   // R1: reset wins over enable
      @(posedge clk);
      #1;
      pos = 0;
      check("R1");
      @(negedge clk);
      rst = 1'b0;
      en  = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: count=%0d dir_up=%0b expected run to finish", count, dir_up);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      do_reset();

      // R3 R4 R5 R6: three full sweeps, enable held high
      for (int i = 0; i < 3 * PER; i++) tick(1'b1);

      // R2: enable dropped every third cycle
      for (int i = 0; i < 3 * PER; i++) tick((i % 3) != 2);

      // R2 R7: park with enable low on each pre-turnaround count and extreme
      for (int k = 0; k < 4; k++) begin
         int stop_at;
         case (k)
            0:       stop_at = MAXV - 1;
            1:       stop_at = MAXV;
            2:       stop_at = PER - 1;
            default: stop_at = 0;
         endcase
         while (pos != stop_at) tick(1'b1);
         for (int j = 0; j < 4; j++) tick(1'b0);
         tick(1'b1);
      end

      // R1: reset in mid sweep while counting down
      while (pos != MAXV + 2) tick(1'b1);
      do_reset();

      // R9: period of the bounce with enable held high
      begin
         int cyc = 0;
         do begin
            tick(1'b1);
            cyc++;
         end while (count != '0 && cyc < 4 * PER);
         n_checks++;
         if (cyc != PER) begin
            n_fails++;
            $display("FAIL R9: period=%0d expected %0d", cyc, PER);
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule